// File: doc/BRIEF.md
# Three-Stage Programmable Sample-Rate Decimator

This block takes a complex baseband stream that carries a new I/Q pair on every clock of a 122.88 MHz domain. It brings that stream down to a lower output rate through three cascaded integrator-comb decimators. The first and last stages always divide by 8. The middle stage divides by a runtime value N, which is read from a plain rate input. The overall reduction is therefore 64·N. With N between 2 and 40, the output rate runs from 960 ksps down to 48 ksps.

Every stage keeps full precision: each stage's register width is its input width plus the order times log2 of that stage's largest ratio. Only the final result is cut down, to a 24-bit word taken from its most significant end. A new rate never breaks a sample that is already in flight. The block reads the rate input only when an output sample completes. If the clamped value differs from the rate in use, the block clears the middle and last stages and blanks the output until data produced entirely under the new rate has passed through.

Top module: `cic3_decim`

## Requirements
- R1: `out_vld` is high for exactly one clock per output sample, and in steady state consecutive pulses are exactly 64·N clocks apart.
- R2: The rate input is read as an unsigned number. Values below 2 behave as 2, values above 40 behave as 40, and the rate in use always lies within 2..40.
- R3: For a constant signed input x held long enough, each output equals floor(x·(64·N)^ORDER / 2^(IN_W+12·ORDER−24)), which is the top 24 bits of the full-precision result (x·N²/16 for IN_W=16, ORDER=2).
- R4: The rate input is sampled only at the completion of a final-stage sample. The sample in progress when the rate input changes is delivered on the old spacing, with the old gain.
- R5: When the applied rate changes, the middle and last stages restart from zero. The next ORDER+1 final-stage samples are suppressed. The first visible output under the new rate already has its exact steady value, no earlier than (ORDER+1)·64·N_new clocks after the last old output.
- R6: I and Q are filtered independently and appear together on the same `out_vld` pulse.
- R7: `out_i` and `out_q` keep their values between `out_vld` pulses.
- R8: During reset, `out_vld`, `out_i` and `out_q` are zero. After reset the first ORDER+1 final-stage samples are suppressed, so the first visible output is already exact.
- R9: A rate input that clamps to the rate already in use causes no restart: pulses continue at 64·N spacing with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one input pair per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_i | input | IN_W | Signed in-phase input sample |
| in_q | input | IN_W | Signed quadrature input sample |
| rate_n | input | RATE_W | Requested middle-stage ratio, clamped to 2..40 |
| out_vld | output | 1 | One-clock strobe marking a new output pair |
| out_i | output | OUT_W | Decimated in-phase word, top bits of the full result |
| out_q | output | OUT_W | Decimated quadrature word, top bits of the full result |

## Verification
The properties rely on the 64·N output spacing being far longer than one clock. A restart pulse can therefore never meet another restart or a second strobe on the next cycle. They also take it that reset is held from time zero.

The stimulus holds each input pair constant for a whole settling period. It changes the rate input only shortly after an observed strobe, and changes the data input only after the old-rate sample has been delivered. Under that discipline, every compared value is a closed-form DC gain.

// File: rtl/cic_pkg.sv
// Shared constants and width arithmetic for the decimator.
// Assumes ratios handed to grown_width are at least 2.
package cic_pkg;
    // number of parallel data channels (I and Q)
    localparam int NUM_CH = 2;

    // register width that holds an order-M CIC with ratio up to max_r without overflow
    function automatic int grown_width(int in_w, int order, int max_r);
        return in_w + order * $clog2(max_r);
    endfunction
endpackage

// File: rtl/cic_stage.sv
// One decimating integrator-comb stage.
// Integrators run on every accepted input; the combs run once per
// 'ratio' inputs. Arithmetic wraps modulo 2^ACC_W, which is exact while the
// true gain fits ACC_W. Assumes ratio stays within 1..MAX_R and only changes
// together with clr.
module cic_stage #(
    parameter  int IN_W  = 16,
    parameter  int ORDER = 2,
    parameter  int MAX_R = 8,
    localparam int ACC_W = cic_pkg::grown_width(IN_W, ORDER, MAX_R),
    parameter  int OUT_W = ACC_W,
    localparam int CNT_W = $clog2(MAX_R + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic [CNT_W-1:0]        ratio,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_data
);
    logic signed [ACC_W-1:0] ext_in;
    logic signed [ACC_W-1:0] integ [ORDER];
    logic signed [ACC_W-1:0] dly   [ORDER];
    logic signed [ACC_W-1:0] diff  [ORDER+1];
    logic [CNT_W-1:0]        cnt;
    logic                    dump;

    assign ext_in = ACC_W'(in_data);
    assign dump   = in_vld && (cnt == ratio - CNT_W'(1));

    // integrator cascade, one delay per section
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int k = 0; k < ORDER; k++) integ[k] <= '0;
        end else if (in_vld) begin
            integ[0] <= integ[0] + ext_in;
            for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
        end
    end

    // comb differences at the low rate, from the last integrator
    always_comb begin
        diff[0] = integ[ORDER-1];
        for (int k = 0; k < ORDER; k++) diff[k+1] = diff[k] - dly[k];
    end

    // decimation counter, comb delays and the registered output
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
        end else begin
            out_vld <= dump;
            if (in_vld) cnt <= dump ? '0 : cnt + CNT_W'(1);
            if (dump) begin
                for (int k = 0; k < ORDER; k++) dly[k] <= diff[k];
                out_data <= diff[ORDER][ACC_W-1 -: OUT_W];
            end
        end
    end
endmodule

// File: rtl/cic_chain.sv
// Three cascaded CIC stages for one data channel: fixed R_FIRST, programmable
// middle ratio, fixed R_LAST. Full precision is kept between stages and the
// final word is the top OUT_W bits. Assumes mid_ratio changes only with mid_clr.
module cic_chain #(
    parameter  int IN_W    = 16,
    parameter  int ORDER   = 2,
    parameter  int R_FIRST = 8,
    parameter  int R_LAST  = 8,
    parameter  int MID_MAX = 40,
    parameter  int OUT_W   = 24,
    localparam int MID_CW  = $clog2(MID_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mid_clr,
    input  logic [MID_CW-1:0]       mid_ratio,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_word
);
    localparam int W1    = cic_pkg::grown_width(IN_W, ORDER, R_FIRST);
    localparam int W2    = cic_pkg::grown_width(W1, ORDER, MID_MAX);
    localparam int CW1   = $clog2(R_FIRST + 1);
    localparam int CW3   = $clog2(R_LAST + 1);

    logic                 v1, v2;
    logic signed [W1-1:0] d1;
    logic signed [W2-1:0] d2;

    cic_stage #(.IN_W(IN_W), .ORDER(ORDER), .MAX_R(R_FIRST)) u_first (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .in_vld(1'b1), .in_data(in_data),
        .ratio(CW1'(R_FIRST)), .out_vld(v1), .out_data(d1)
    );

    cic_stage #(.IN_W(W1), .ORDER(ORDER), .MAX_R(MID_MAX)) u_mid (
        .clk(clk), .rst_n(rst_n), .clr(mid_clr), .in_vld(v1), .in_data(d1),
        .ratio(mid_ratio), .out_vld(v2), .out_data(d2)
    );

    cic_stage #(.IN_W(W2), .ORDER(ORDER), .MAX_R(R_LAST), .OUT_W(OUT_W)) u_last (
        .clk(clk), .rst_n(rst_n), .clr(mid_clr), .in_vld(v2), .in_data(d2),
        .ratio(CW3'(R_LAST)), .out_vld(out_vld), .out_data(out_word)
    );
endmodule

// File: rtl/decim_rate_ctrl.sv
// Rate sequencer: clamps the requested ratio, applies it only at a final-stage
// sample boundary, issues a one-cycle clear for the downstream stages and
// suppresses the next FLUSH boundaries. Assumes boundaries are never adjacent.
module decim_rate_ctrl #(
    parameter  int N_MIN  = 2,
    parameter  int N_MAX  = 40,
    parameter  int RATE_W = 6,
    parameter  int FLUSH  = 3,
    localparam int N_W    = $clog2(N_MAX + 1),
    localparam int FL_W   = $clog2(FLUSH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_req,
    input  logic              boundary,
    output logic [N_W-1:0]    active_n,
    output logic              stage_clr,
    output logic              emit
);
    logic [N_W-1:0]  want_n;
    logic [FL_W-1:0] flush_left;

    // clamp the request into the supported range
    always_comb begin
        if (rate_req < RATE_W'(N_MIN))      want_n = N_W'(N_MIN);
        else if (rate_req > RATE_W'(N_MAX)) want_n = N_W'(N_MAX);
        else                                want_n = N_W'(rate_req);
    end

    // apply a new rate at a boundary and count down the flush window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_n   <= N_W'(N_MIN);
            stage_clr  <= 1'b0;
            flush_left <= FL_W'(FLUSH);
        end else begin
            stage_clr <= 1'b0;
            if (boundary) begin
                if (want_n != active_n) begin
                    active_n   <= want_n;
                    stage_clr  <= 1'b1;
                    flush_left <= FL_W'(FLUSH);
                end else if (flush_left != '0) begin
                    flush_left <= flush_left - FL_W'(1);
                end
            end
        end
    end

    assign emit = boundary && (flush_left == '0);
endmodule

// File: rtl/cic3_decim.sv
// Top level: I and Q chains sharing one rate sequencer, with registered
// 24-bit outputs and a one-clock strobe. Assumes one input pair per clock.
module cic3_decim #(
    parameter  int IN_W    = 16,
    parameter  int ORDER   = 2,
    parameter  int R_FIRST = 8,
    parameter  int R_LAST  = 8,
    parameter  int N_MIN   = 2,
    parameter  int N_MAX   = 40,
    parameter  int RATE_W  = 6,
    parameter  int OUT_W   = 24,
    localparam int N_W     = $clog2(N_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    input  logic [RATE_W-1:0]       rate_n,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int NCH = cic_pkg::NUM_CH;

    logic signed [IN_W-1:0]  ch_in   [NCH];
    logic signed [OUT_W-1:0] ch_word [NCH];
    logic [NCH-1:0]          ch_vld;
    logic                    boundary;
    logic                    stage_clr;
    logic                    emit;
    logic [N_W-1:0]          active_n;

    assign ch_in[0] = in_i;
    assign ch_in[1] = in_q;
    assign boundary = &ch_vld;

    decim_rate_ctrl #(
        .N_MIN(N_MIN), .N_MAX(N_MAX), .RATE_W(RATE_W), .FLUSH(ORDER + 1)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rate_req(rate_n), .boundary(boundary),
        .active_n(active_n), .stage_clr(stage_clr), .emit(emit)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        cic_chain #(
            .IN_W(IN_W), .ORDER(ORDER), .R_FIRST(R_FIRST), .R_LAST(R_LAST),
            .MID_MAX(N_MAX), .OUT_W(OUT_W)
        ) u_chain (
            .clk(clk), .rst_n(rst_n), .mid_clr(stage_clr), .mid_ratio(active_n),
            .in_data(ch_in[ch]), .out_vld(ch_vld[ch]), .out_word(ch_word[ch])
        );
    end

    // register the visible output pair and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_i   <= '0;
            out_q   <= '0;
        end else begin
            out_vld <= emit;
            if (emit) begin
                out_i <= ch_word[0];
                out_q <= ch_word[1];
            end
        end
    end
endmodule

// File: rtl/cic3_decim_chk.sv
// Checker for cic3_decim: temporal properties on the strobe, the held output
// data, the applied rate and the restart pulse. Assumes reset held from time zero.
module cic3_decim_chk #(
    parameter int N_MIN = 2,
    parameter int N_MAX = 40,
    parameter int N_W   = 6,
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q,
    input logic             stage_clr,
    input logic             boundary,
    input logic [N_W-1:0]   active_n
);
    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    p_rate_in_limits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_n >= N_W'(N_MIN)) && (active_n <= N_W'(N_MAX)));

    p_restart_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clr |-> $past(boundary));

    p_quiet_after_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clr |=> !out_vld);

    p_restart_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clr |=> !stage_clr);

    p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind cic3_decim cic3_decim_chk #(
    .N_MIN(N_MIN), .N_MAX(N_MAX), .N_W(N_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_vld(out_vld), .out_i(out_i), .out_q(out_q),
    .stage_clr(stage_clr), .boundary(boundary), .active_n(active_n)
);

// File: tb/sim_cic3_decim.sv
module sim_cic3_decim;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W   = 16;
    localparam int ORDER  = 2;
    localparam int RATE_W = 6;
    localparam int OUT_W  = 24;
    localparam int SHIFT  = IN_W + 12 * ORDER - OUT_W;
    localparam int FLUSH_N = ORDER + 1;
    localparam int NPT    = 9;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [IN_W-1:0]  in_i = '0;
    logic signed [IN_W-1:0]  in_q = '0;
    logic [RATE_W-1:0]       rate_n = RATE_W'(2);
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_i;
    logic signed [OUT_W-1:0] out_q;

    cic3_decim #(.IN_W(IN_W), .ORDER(ORDER), .RATE_W(RATE_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .in_q(in_q), .rate_n(rate_n),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit dead  = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint gain_out(longint x, int n);
        longint g = 1;
        for (int k = 0; k < ORDER; k++) g = g * 64 * n;
        return (x * g) >>> SHIFT;
    endfunction

    function automatic int clamp_n(int r);
        return (r < 2) ? 2 : ((r > 40) ? 40 : r);
    endfunction

    // wait for the next strobe at a falling edge; watchdog counts as a failure
    task automatic wait_vld(output longint t);
        t = 0;
        if (dead) return;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (out_vld) begin
                t = cyc;
                return;
            end
        end
        dead = 1'b1;
        check(1'b0, "watchdog", "no strobe within limit", 0, 1);
    endtask

    int rates [NPT] = '{7, 40, 3, 63, 16, 1, 5, 41, 0};
    int xis   [NPT] = '{-20000, 32767, 555, -32768, 4321, -7, 30000, -1234, 9999};
    int xqs   [NPT] = '{15000, -32768, -999, 32767, -4321, 123, -30000, 2468, -8888};

    initial begin
        longint t0, t1, t2, t3, prev;
        int cur_n, cur_xi, cur_xq, new_n;
        string rq;

        repeat (4) @(negedge clk);
        // R8: outputs held at zero during reset
        check(out_vld == 1'b0, "R8", "reset strobe", longint'(out_vld), 0);
        check(out_i == '0, "R8", "reset out_i", longint'(out_i), 0);
        check(out_q == '0, "R8", "reset out_q", longint'(out_q), 0);

        cur_n = 2; cur_xi = 1000; cur_xq = -3000;
        in_i = IN_W'(cur_xi); in_q = IN_W'(cur_xq); rate_n = RATE_W'(2);
        rst_n = 1'b1;
        t0 = cyc;
        wait_vld(t1);
        // R8: first visible output after reset is exact and comes after the flush
        check(t1 - t0 >= FLUSH_N * 128, "R8", "first strobe delay", t1 - t0, FLUSH_N * 128);
        check(longint'(out_i) == gain_out(cur_xi, 2), "R8", "first out_i",
              longint'(out_i), gain_out(cur_xi, 2));
        check(longint'(out_q) == gain_out(cur_xq, 2), "R6", "first out_q",
              longint'(out_q), gain_out(cur_xq, 2));
        prev = t1;
        rq = "R3";

        for (int p = 0; p < NPT; p++) begin
            if (dead) break;
            // steady spacing and gain under the current rate
            wait_vld(t1);
            check(t1 - prev == 64 * cur_n, "R1", {rq, " spacing"}, t1 - prev, 64 * cur_n);
            check(longint'(out_i) == gain_out(cur_xi, cur_n), rq, "steady out_i",
                  longint'(out_i), gain_out(cur_xi, cur_n));
            check(longint'(out_q) == gain_out(cur_xq, cur_n), "R6", "steady out_q",
                  longint'(out_q), gain_out(cur_xq, cur_n));
            @(negedge clk);
            check(out_vld == 1'b0, "R1", "strobe width", longint'(out_vld), 0);
            // request a new rate in the middle of a sample
            rate_n = RATE_W'(rates[p]);
            new_n  = clamp_n(rates[p]);
            repeat (3) @(negedge clk);
            check(longint'(out_i) == gain_out(cur_xi, cur_n), "R7", "held out_i",
                  longint'(out_i), gain_out(cur_xi, cur_n));
            // R4: the sample in progress completes on the old rate
            wait_vld(t2);
            check(t2 - t1 == 64 * cur_n, "R4", "old-rate spacing", t2 - t1, 64 * cur_n);
            check(longint'(out_i) == gain_out(cur_xi, cur_n), "R4", "old-rate out_i",
                  longint'(out_i), gain_out(cur_xi, cur_n));
            cur_xi = xis[p]; cur_xq = xqs[p];
            in_i = IN_W'(cur_xi); in_q = IN_W'(cur_xq);
            // R5: blanked restart, first visible output exact
            wait_vld(t3);
            rq = (rates[p] < 2 || rates[p] > 40) ? "R2" : "R3";
            check(t3 - t2 >= FLUSH_N * 64 * new_n, "R5", "restart gap",
                  t3 - t2, FLUSH_N * 64 * new_n);
            check(longint'(out_i) == gain_out(cur_xi, new_n), "R5", {rq, " first out_i"},
                  longint'(out_i), gain_out(cur_xi, new_n));
            check(longint'(out_q) == gain_out(cur_xq, new_n), "R6", "first out_q",
                  longint'(out_q), gain_out(cur_xq, new_n));
            cur_n = new_n;
            prev = t3;
        end

        // R9: a request clamping to the rate in use (2) does not restart
        if (!dead) begin
            rate_n = RATE_W'(1);
            for (int k = 0; k < 2; k++) begin
                wait_vld(t1);
                check(t1 - prev == 64 * cur_n, "R9", "no-restart spacing", t1 - prev, 64 * cur_n);
                check(longint'(out_i) == gain_out(cur_xi, cur_n), "R9", "no-restart out_i",
                      longint'(out_i), gain_out(cur_xi, cur_n));
                prev = t1;
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule